// File: doc/BRIEF.md
# PC Card Common Memory Cycle Controller

This block sits on the host side of a 16-bit PC Card slot and runs common-memory read and write cycles. The host offers one request at a time: an address, a direction, a byte or word width, write data and a two-bit speed grade. The block then drives the card address, the two active-low chip selects, the read strobe and the write strobe, and the direction of the data bus. When the cycle ends it returns the read data together with a single-cycle done pulse.

The strobe width comes from the speed grade. The grade's nominal time in nanoseconds is converted to a whole number of system clocks, rounding up, using a clock-period parameter. Once that minimum width has elapsed, the card may stretch the strobe by holding its active-low stall input low. The stall input is synchronised before use. A stall that lasts too long is cut off by a timeout counter, and the cycle is then reported as an error.

Top module: `pcmem_host_ctrl`

## Requirements
- R1: Grade code 0, 1, 2 and 3 select 250, 200, 150 and 100 ns. With no stall, the active strobe stays low for exactly ceil(grade_ns / CLK_PERIOD_NS) clocks.
- R2: `card_stall_n` passes through a two-flop synchroniser. While the synchronised value is low after the minimum width, the strobe stays low. After `card_stall_n` returns high during strobe cycle K, the strobe width is max(minimum, K+2) clocks.
- R3: A word access (`req_word`=1) drives `cs_lo_n` and `cs_hi_n` both low, from the setup clock through the hold clock.
- R4: A byte access drives only `cs_lo_n` low when `req_addr[0]`=0, and only `cs_hi_n` low when `req_addr[0]`=1.
- R5: The address and chip selects are asserted for exactly one clock before the strobe falls. They are held for exactly one clock after the strobe rises. They are released in the clock that carries `done`.
- R6: A write (`req_write`=1) uses only `wr_strb_n`. It holds `data_oe`=1 with `card_dout` equal to the write data from the setup clock through the hold clock.
- R7: A read uses only `rd_strb_n` and keeps `data_oe`=0. `rd_data` equals `card_din` as sampled on the clock edge where `rd_strb_n` rises.
- R8: If the stall is still asserted TIMEOUT_CYC clocks after the minimum width, the strobe ends after minimum+TIMEOUT_CYC clocks. `timeout_err` is then high in the done clock; otherwise it stays low.
- R9: `busy` is high from the clock after acceptance until `done`. `done` is a one-clock pulse in the clock after the hold clock, with `busy` low. A request raised while `busy` is high is ignored.
- R10: During and after reset, before any request, `busy`, `done`, `timeout_err` and `data_oe` are 0, and both chip selects and both strobes are 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request strobe, sampled while idle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_word | input | 1 | 1 = 16-bit access, 0 = 8-bit access |
| req_addr | input | ADDR_W | Card address |
| req_wdata | input | DATA_W | Write data |
| req_grade | input | 2 | Speed grade: 0=250, 1=200, 2=150, 3=100 ns |
| busy | output | 1 | A cycle is in progress |
| done | output | 1 | One-clock completion pulse |
| timeout_err | output | 1 | The cycle ended by stall timeout (valid with done) |
| rd_data | output | DATA_W | Captured read data |
| card_addr | output | ADDR_W | Address to the card |
| cs_lo_n | output | 1 | Low-byte chip select, active low |
| cs_hi_n | output | 1 | High-byte chip select, active low |
| rd_strb_n | output | 1 | Read strobe, active low |
| wr_strb_n | output | 1 | Write strobe, active low |
| data_oe | output | 1 | 1 = the host drives the data bus |
| card_dout | output | DATA_W | Data driven to the card |
| card_din | input | DATA_W | Data from the card |
| card_stall_n | input | 1 | Card stall request, active low, asynchronous |

## Verification
The bench builds the block with a 5 ns clock period, so the four grades map to 50, 40, 30 and 20 clocks and every grade runs within a short test. It shortens TIMEOUT_CYC to 16 so that a stall that never ends reaches the timeout path after 36 strobe clocks at the fastest grade. ADDR_W is 10, which still exposes the address bit that picks the byte lane. The default timeout of 256 would leave the error path out of reach in a compact run.

// File: rtl/pcmem_pkg.sv
package pcmem_pkg;

   typedef enum logic [1:0] {
      CYC_IDLE   = 2'd0,
      CYC_SETUP  = 2'd1,
      CYC_STROBE = 2'd2,
      CYC_HOLD   = 2'd3
   } cyc_state_e;

   // nominal cycle time of a speed-grade code, in nanoseconds
   function automatic int unsigned grade_ns(input logic [1:0] code);
      case (code)
         2'd0:    return 250;
         2'd1:    return 200;
         2'd2:    return 150;
         default: return 100;
      endcase
   endfunction

   // whole clocks covering a time span, rounding up
   function automatic int unsigned ns_to_clocks(input int unsigned ns, input int unsigned period);
      return (ns + period - 1) / period;
   endfunction

endpackage

// File: rtl/pcmem_sync.sv
module pcmem_sync #(
   parameter int unsigned STAGES  = 2,
   parameter bit          RST_VAL = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);

   if (STAGES < 2) begin : g_bad_stages
      $error("pcmem_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0] chain;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= {STAGES{RST_VAL}};
      else        chain <= {chain[STAGES-2:0], d};
   end

   assign q = chain[STAGES-1];

   // R2: the last stage follows the stage before it by one clock
   p_sync_shift_r2: assert property (@(posedge clk) disable iff (!rst_n)
      chain[STAGES-1] == $past(chain[STAGES-2]));

endmodule

// File: rtl/pcmem_strobe_timer.sv
module pcmem_strobe_timer #(
   parameter int unsigned CNT_W       = 9,
   parameter int unsigned EXT_W       = 9,
   parameter int unsigned TIMEOUT_CYC = 256
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clear,
   input  logic             run,
   input  logic [CNT_W-1:0] min_cnt,
   input  logic             stalled,
   output logic             min_met,
   output logic             tmo_hit
);

   logic [CNT_W-1:0] width_cnt;
   logic [EXT_W-1:0] ext_cnt;

   assign min_met = width_cnt >= min_cnt;
   assign tmo_hit = run && min_met && stalled && (ext_cnt == EXT_W'(TIMEOUT_CYC));

   // width_cnt holds the 1-based index of the current strobe clock
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         width_cnt <= '0;
         ext_cnt   <= '0;
      end else if (clear) begin
         width_cnt <= CNT_W'(1);
         ext_cnt   <= '0;
      end else if (run) begin
         if (!(&width_cnt)) width_cnt <= width_cnt + 1'b1;
         if (min_met && stalled && !tmo_hit) ext_cnt <= ext_cnt + 1'b1;
      end
   end

   // R8: extension count never passes the limit
   p_ext_bound_r8: assert property (@(posedge clk) disable iff (!rst_n)
      ext_cnt <= EXT_W'(TIMEOUT_CYC));
   // R8: no extension is counted before the minimum width
   p_no_early_ext_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (run && !min_met) |-> (ext_cnt == '0));

endmodule

// File: rtl/pcmem_lane_decode.sv
module pcmem_lane_decode (
   input  logic active,
   input  logic word,
   input  logic addr_lsb,
   output logic lo_sel_n,
   output logic hi_sel_n
);

   assign lo_sel_n = !(active && (word || !addr_lsb));
   assign hi_sel_n = !(active && (word ||  addr_lsb));

   // R4: the two selects are never both asserted on a byte access
   always_comb begin
      if (active && !word)
         a_byte_one_lane_r4: assert (lo_sel_n != hi_sel_n);
   end

endmodule

// File: rtl/pcmem_host_ctrl.sv
module pcmem_host_ctrl
   import pcmem_pkg::*;
#(
   parameter int unsigned ADDR_W        = 16,
   parameter int unsigned DATA_W        = 16,
   parameter int unsigned CLK_PERIOD_NS = 5,
   parameter int unsigned TIMEOUT_CYC   = 256,
   parameter int unsigned SYNC_STAGES   = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic              req_write,
   input  logic              req_word,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [DATA_W-1:0] req_wdata,
   input  logic [1:0]        req_grade,
   output logic              busy,
   output logic              done,
   output logic              timeout_err,
   output logic [DATA_W-1:0] rd_data,
   output logic [ADDR_W-1:0] card_addr,
   output logic              cs_lo_n,
   output logic              cs_hi_n,
   output logic              rd_strb_n,
   output logic              wr_strb_n,
   output logic              data_oe,
   output logic [DATA_W-1:0] card_dout,
   input  logic [DATA_W-1:0] card_din,
   input  logic              card_stall_n
);

   localparam int unsigned SLOWEST = ns_to_clocks(grade_ns(2'd0), CLK_PERIOD_NS);
   localparam int unsigned CNT_W   = $clog2(SLOWEST + TIMEOUT_CYC + 2);
   localparam int unsigned EXT_W   = $clog2(TIMEOUT_CYC + 1) + 1;

   if (ADDR_W < 1) begin : g_bad_addr
      $error("pcmem_host_ctrl: ADDR_W must be at least 1");
   end
   if (DATA_W < 16 || (DATA_W % 2) != 0) begin : g_bad_data
      $error("pcmem_host_ctrl: DATA_W must be even and at least 16");
   end
   if (CLK_PERIOD_NS < 1) begin : g_bad_period
      $error("pcmem_host_ctrl: CLK_PERIOD_NS must be at least 1");
   end
   if (TIMEOUT_CYC < 1) begin : g_bad_timeout
      $error("pcmem_host_ctrl: TIMEOUT_CYC must be at least 1");
   end

   // minimum strobe clocks for each grade, computed at elaboration
   logic [CNT_W-1:0] grade_tbl [4];
   for (genvar g = 0; g < 4; g++) begin : g_grade
      localparam int unsigned CLKS = ns_to_clocks(grade_ns(2'(g)), CLK_PERIOD_NS);
      assign grade_tbl[g] = CNT_W'(CLKS);
   end

   cyc_state_e        st;
   logic              lat_write;
   logic              lat_word;
   logic [ADDR_W-1:0] lat_addr;
   logic [DATA_W-1:0] lat_wdata;
   logic [CNT_W-1:0]  lat_min;
   logic [DATA_W-1:0] rd_q;
   logic              done_q;
   logic              err_q;
   logic              stall_sync;
   logic              stalled;
   logic              min_met;
   logic              tmo_hit;
   logic              end_strobe;
   logic              active;
   logic              in_strobe;

   pcmem_sync #(
      .STAGES  (SYNC_STAGES),
      .RST_VAL (1'b1)
   ) u_stall_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (card_stall_n),
      .q     (stall_sync)
   );

   assign stalled = !stall_sync;

   pcmem_strobe_timer #(
      .CNT_W       (CNT_W),
      .EXT_W       (EXT_W),
      .TIMEOUT_CYC (TIMEOUT_CYC)
   ) u_timer (
      .clk     (clk),
      .rst_n   (rst_n),
      .clear   (st == CYC_SETUP),
      .run     (in_strobe),
      .min_cnt (lat_min),
      .stalled (stalled),
      .min_met (min_met),
      .tmo_hit (tmo_hit)
   );

   assign active     = (st != CYC_IDLE);
   assign in_strobe  = (st == CYC_STROBE);
   assign end_strobe = in_strobe && min_met && (!stalled || tmo_hit);

   pcmem_lane_decode u_lanes (
      .active   (active),
      .word     (lat_word),
      .addr_lsb (lat_addr[0]),
      .lo_sel_n (cs_lo_n),
      .hi_sel_n (cs_hi_n)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st        <= CYC_IDLE;
         lat_write <= 1'b0;
         lat_word  <= 1'b0;
         lat_addr  <= '0;
         lat_wdata <= '0;
         lat_min   <= '0;
         rd_q      <= '0;
         done_q    <= 1'b0;
         err_q     <= 1'b0;
      end else begin
         done_q <= 1'b0;
         case (st)
            CYC_IDLE: begin
               if (req_valid) begin
                  lat_write <= req_write;
                  lat_word  <= req_word;
                  lat_addr  <= req_addr;
                  lat_wdata <= req_wdata;
                  lat_min   <= grade_tbl[req_grade];
                  err_q     <= 1'b0;
                  st        <= CYC_SETUP;
               end
            end
            CYC_SETUP: st <= CYC_STROBE;
            CYC_STROBE: begin
               if (end_strobe) begin
                  err_q <= tmo_hit;
                  if (!lat_write) rd_q <= card_din;
                  st <= CYC_HOLD;
               end
            end
            CYC_HOLD: begin
               done_q <= 1'b1;
               st     <= CYC_IDLE;
            end
            default: st <= CYC_IDLE;
         endcase
      end
   end

   assign busy        = active;
   assign done        = done_q;
   assign timeout_err = done_q && err_q;
   assign rd_data     = rd_q;
   assign card_addr   = lat_addr;
   assign card_dout   = lat_wdata;
   assign data_oe     = active && lat_write;
   assign rd_strb_n   = !(in_strobe && !lat_write);
   assign wr_strb_n   = !(in_strobe &&  lat_write);

   // R6/R7: only one strobe at a time
   p_one_strobe_r6: assert property (@(posedge clk) disable iff (!rst_n)
      rd_strb_n || wr_strb_n);
   // R5: a strobe is only active under an asserted chip select
   p_strobe_under_cs_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (!rd_strb_n || !wr_strb_n) |-> (!cs_lo_n || !cs_hi_n));
   // R5: a select was already asserted the clock before the strobe fell
   p_setup_clock_r5: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(rd_strb_n && wr_strb_n) |-> $past(!cs_lo_n || !cs_hi_n));
   // R4: a byte access asserts one select only
   p_byte_lane_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !lat_word) |-> ($countones({cs_lo_n, cs_hi_n}) == 1));
   // R3: a word access asserts both selects
   p_word_lanes_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && lat_word) |-> (!cs_lo_n && !cs_hi_n));
   // R7: the host does not drive the bus during a read strobe
   p_read_no_drive_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_strb_n |-> !data_oe);
   // R2: a synchronised stall after the minimum keeps the strobe
   p_stall_holds_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (in_strobe && min_met && stalled && !tmo_hit) |=> (st == CYC_STROBE));
   // R8: the error flag only appears with done
   p_err_with_done_r8: assert property (@(posedge clk) disable iff (!rst_n)
      timeout_err |-> done);
   // R9: done lasts one clock and comes with busy low
   p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);
   p_done_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !busy);
   // R9: a request during busy leaves the address untouched
   p_ignore_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && req_valid) |=> $stable(card_addr));

endmodule

// File: tb/test_pcmem_host_ctrl.sv
module test_pcmem_host_ctrl;

   localparam int AW  = 10;
   localparam int DW  = 16;
   localparam int PER = 5;
   localparam int TMO = 16;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          req_valid = 1'b0;
   logic          req_write = 1'b0;
   logic          req_word = 1'b0;
   logic [AW-1:0] req_addr = '0;
   logic [DW-1:0] req_wdata = '0;
   logic [1:0]    req_grade = '0;
   logic          busy, done, timeout_err;
   logic [DW-1:0] rd_data;
   logic [AW-1:0] card_addr;
   logic          cs_lo_n, cs_hi_n, rd_strb_n, wr_strb_n, data_oe;
   logic [DW-1:0] card_dout;
   logic [DW-1:0] card_din = '0;
   logic          card_stall_n = 1'b1;

   always #2.5 clk = ~clk;

   pcmem_host_ctrl #(
      .ADDR_W (AW), .DATA_W (DW), .CLK_PERIOD_NS (PER),
      .TIMEOUT_CYC (TMO), .SYNC_STAGES (2)
   ) i_pcmem_host_ctrl (
      .clk (clk), .rst_n (rst_n),
      .req_valid (req_valid), .req_write (req_write), .req_word (req_word),
      .req_addr (req_addr), .req_wdata (req_wdata), .req_grade (req_grade),
      .busy (busy), .done (done), .timeout_err (timeout_err), .rd_data (rd_data),
      .card_addr (card_addr), .cs_lo_n (cs_lo_n), .cs_hi_n (cs_hi_n),
      .rd_strb_n (rd_strb_n), .wr_strb_n (wr_strb_n), .data_oe (data_oe),
      .card_dout (card_dout), .card_din (card_din), .card_stall_n (card_stall_n)
   );

   typedef struct {
      bit            wr;
      logic [AW-1:0] addr;
      logic [DW-1:0] wdata;
      logic [DW-1:0] rdata;
      int            width;
      bit            err;
      logic [1:0]    ce;   // {hi, lo}, active low
   } exp_t;

   exp_t q[$];
   int   n_checks = 0;
   int   n_fail = 0;
   int   n_done = 0;
   int   stall_mode = 0;   // 0 none, 1 release at strobe clock K, 2 never release
   int   stall_k = 0;

   task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
      end
   endtask

   function automatic int min_clocks(input logic [1:0] g);
      int ns;
      ns = (g == 2'd0) ? 250 : (g == 2'd1) ? 200 : (g == 2'd2) ? 150 : 100;
      return (ns + PER - 1) / PER;
   endfunction

   task automatic run_req(input bit wr, input bit word, input logic [AW-1:0] addr,
                          input logic [DW-1:0] wd, input logic [DW-1:0] rd,
                          input logic [1:0] g, input int mode, input int k,
                          input bit extra);
      exp_t e;
      int   n;
      int   old;
      n = min_clocks(g);
      e.wr = wr; e.addr = addr; e.wdata = wd; e.rdata = rd; e.err = (mode == 2);
      if (mode == 1)      e.width = (k + 2 > n) ? k + 2 : n;
      else if (mode == 2) e.width = n + TMO;
      else                e.width = n;
      e.ce = word ? 2'b00 : (addr[0] ? 2'b01 : 2'b10);
      q.push_back(e);
      stall_mode = mode;
      stall_k = k;
      card_din = rd;
      old = n_done;
      @(negedge clk);
      req_valid = 1'b1; req_write = wr; req_word = word;
      req_addr = addr; req_wdata = wd; req_grade = g;
      @(negedge clk);
      req_valid = 1'b0;
      if (extra) begin
         repeat (4) @(negedge clk);
         req_valid = 1'b1; req_addr = ~addr; req_write = ~wr;
         @(negedge clk);
         req_valid = 1'b0;
      end
      while (n_done == old) @(negedge clk);
   endtask

   // card stall model and scoreboard monitor, both on the falling edge
   int         sc = 0;
   int         phase = 0;
   int         w = 0;
   bit         data_bad = 1'b0;
   bit         prev_strb = 1'b0;
   logic [1:0] prev_ce = 2'b11;

   always @(negedge clk) begin
      logic       strb;
      logic [1:0] ce;
      exp_t       e;
      strb = !rd_strb_n || !wr_strb_n;
      ce = {cs_hi_n, cs_lo_n};
      if (strb) begin
         sc++;
         card_stall_n <= (stall_mode == 0) ? 1'b1 : (stall_mode == 1) ? (sc >= stall_k) : 1'b0;
      end else begin
         sc = 0;
         card_stall_n <= 1'b1;
      end
      if (rst_n) begin
         if (q.size() > 0) e = q[0];
         case (phase)
            0: begin
               if (done) chk(1'b0, "R9 unexpected done", 1, 0);
               if (strb) begin
                  chk(q.size() > 0, "R9 strobe without request", q.size(), 1);
                  chk(prev_ce == e.ce && !prev_strb, "R5 setup clock selects", prev_ce, e.ce);
                  chk(e.wr ? (!wr_strb_n && rd_strb_n) : (!rd_strb_n && wr_strb_n),
                      e.wr ? "R6 write strobe" : "R7 read strobe", {rd_strb_n, wr_strb_n}, e.wr);
                  w = 1;
                  data_bad = 1'b0;
                  phase = 1;
               end
            end
            1: begin
               if (e.wr ? !(data_oe && card_dout == e.wdata) : data_oe) data_bad = 1'b1;
               if (ce != e.ce) data_bad = 1'b1;
               if (strb) w++;
               else begin
                  chk(ce == e.ce, "R3/R4 hold clock selects", ce, e.ce);
                  chk(card_addr == e.addr, "R5 hold address", card_addr, e.addr);
                  chk(!done && busy, "R9 busy in hold", {done, busy}, 1);
                  chk(!data_bad, e.wr ? "R6 write data lanes" : "R7 bus released", data_bad, 0);
                  chk(w == e.width, e.err ? "R8 timeout width" : "R1/R2 strobe width", w, e.width);
                  phase = 2;
               end
            end
            default: begin
               chk(done && !busy, "R9 done pulse", {done, busy}, 2'b10);
               chk(ce == 2'b11 && !data_oe, "R5 release", {ce, data_oe}, 3'b110);
               chk(timeout_err == e.err, "R8 error flag", timeout_err, e.err);
               if (!e.wr) chk(rd_data == e.rdata, "R7 read data", rd_data, e.rdata);
               void'(q.pop_front());
               n_done++;
               phase = 0;
            end
         endcase
      end
      prev_strb = strb;
      prev_ce = ce;
   end

   initial begin
      repeat (150000) @(posedge clk);
      n_fail++;
      n_checks++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      // R10: reset state
      chk(!busy && !done && !timeout_err && !data_oe, "R10 reset flags",
          {busy, done, timeout_err, data_oe}, 0);
      chk(cs_lo_n && cs_hi_n && rd_strb_n && wr_strb_n, "R10 reset selects",
          {cs_lo_n, cs_hi_n, rd_strb_n, wr_strb_n}, 4'hf);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      chk(!busy && cs_lo_n && cs_hi_n, "R10 idle after reset", {busy, cs_lo_n, cs_hi_n}, 3'b011);
      // R1/R3/R7: word read, fastest grade
      run_req(1'b0, 1'b1, 10'h010, 16'h0000, 16'hA5C3, 2'd3, 0, 0, 1'b0);
      // R1/R3/R6: word write, slowest grade
      run_req(1'b1, 1'b1, 10'h122, 16'h5A3C, 16'h0000, 2'd0, 0, 0, 1'b0);
      // R4/R7: byte read, even address
      run_req(1'b0, 1'b0, 10'h204, 16'h0000, 16'h00E7, 2'd1, 0, 0, 1'b0);
      // R4/R6: byte write, odd address
      run_req(1'b1, 1'b0, 10'h0FF, 16'hBE00, 16'h0000, 2'd2, 0, 0, 1'b0);
      // R2: stall beyond the minimum stretches the strobe to K+2
      run_req(1'b0, 1'b1, 10'h033, 16'h0000, 16'h1234, 2'd3, 1, 30, 1'b0);
      // R2: short stall inside the minimum does not lengthen it
      run_req(1'b1, 1'b0, 10'h032, 16'h00AA, 16'h0000, 2'd2, 1, 5, 1'b0);
      // R8: stall that never ends
      run_req(1'b0, 1'b1, 10'h3FE, 16'h0000, 16'hFEED, 2'd3, 2, 0, 1'b0);
      // R8: the next normal cycle reports no error
      run_req(1'b0, 1'b0, 10'h101, 16'h0000, 16'h4400, 2'd3, 0, 0, 1'b0);
      // R9: request during busy is ignored
      run_req(1'b1, 1'b1, 10'h155, 16'hC0DE, 16'h0000, 2'd3, 0, 0, 1'b1);
      repeat (10) @(negedge clk);
      chk(!busy && card_addr == 10'h155, "R9 busy request ignored", card_addr, 10'h155);
      chk(q.size() == 0, "R9 scoreboard empty", q.size(), 0);
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   end

endmodule